// File: doc/BRIEF.md
# Indexed NVRAM Clock Access Port

This block puts a byte store and a set of time-of-day registers behind a four-location I/O window. Software first loads a 16-bit pointer through two window locations, one byte at a time. A third location then moves one byte to or from the byte the pointer selects. Every data write also returns the pointer to zero. Most of the address space is plain storage. The sixteen bytes at the top of the store are registers: alarm and watchdog bytes, a control byte with forced bits, a read-only flags byte, and a BCD calendar clock that can be stopped and restarted.

The store size is a parameter. A variant switch chooses between two register windows. With alarm support, the register window is the top 16 bytes. Without it, only the top 8 bytes are registers and the eight bytes below them become plain storage. The calendar advances once every `TICK_CYCLES` clocks. Accesses use a one-cycle strobe, and read data is returned through a register.

Top module: `nvclk_port`

## Requirements
- R1: A write strobe at window offset 0 loads bits 7:0 of the pointer, and one at offset 1 loads bits 15:8. The other pointer byte is left unchanged.
- R2: A write strobe at offset 3 stores `wdata` into the pointed byte and clears the pointer to 0x0000 on the same edge.
- R3: A read strobe at offset 0, 1 or 2 returns 0xFF. A write strobe at offset 2 changes neither the pointer nor any stored byte.
- R4: Bytes below `MEM_BYTES-16` read back what was last written to them. This also holds for the alarm, interrupt and watchdog bytes at register indices 2 to 7.
- R5: A write to the control byte (index 8) stores `(v & 0x5F) | 0x90`.
- R6: The flags byte (index 0) ignores writes. The spare byte (index 1) always reads 0x00.
- R7: Bit 7 of the seconds byte (index 9) is a stop flag and reads back as written. While it is set, the calendar does not advance. Clearing it restarts counting from the frozen time. A seconds write with an out-of-range value updates only the stop flag.
- R8: Calendar bytes hold BCD values. A write is discarded when it is out of range. The limits are: seconds and minutes at most 59 (value bits 6:0), hours at most 23 (bits 5:0), date 1 to 31 (bits 5:0), month 1 to 12 (bits 4:0), and year at most 99 (all 8 bits). Index order from 9 to 15 is: seconds, minutes, hours, weekday, date, month, year.
- R9: Each second carries into minutes, hours, weekday, date, month and year. Months are 28, 29, 30 or 31 days long. February has 29 days when the year is divisible by four.
- R10: Any pointer at or above `MEM_BYTES` reads 0xFF, and writes to it change no stored byte.
- R11: Reset sets the pointer to 0 and `rdata` to 0xFF, and sets the calendar to 00:00:00, date 1, month 1, year 0, running. Stored bytes keep their values through reset.
- R12: The weekday byte (index 12) keeps bits 2:0 as the weekday and bit 6 as a century flag. The other bits read as zero. The weekday advances at midnight.
- R13: `rdata` changes only on the clock edge that takes a read strobe, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb | input | 1 | One-cycle access strobe |
| we | input | 1 | 1 = write, 0 = read, sampled with `stb` |
| ofs | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The pointer, the stored bytes, the calendar fields and `rdata` all take their new values on the same rising edge that samples the strobe. The bench drives on the falling edge and samples `rdata` on the next falling edge, half a cycle after the register loads. Calendar results are due exactly `TICK_CYCLES` edges after a seconds write, because that write clears the prescaler. The bench therefore runs the clock for a counted number of cycles and then freezes it, well away from the next tick, before it reads any field. Checks that something was ignored read back the pointer target or the byte afterwards through the data location.

// File: rtl/nvclk_pkg.sv
package nvclk_pkg;

   localparam int PTR_W = 16;
   localparam logic [7:0] CTRL_KEEP = 8'h5F;
   localparam logic [7:0] CTRL_SET  = 8'h90;

   typedef enum logic [1:0] {
      OFS_PTR_LO = 2'd0,
      OFS_PTR_HI = 2'd1,
      OFS_SPARE  = 2'd2,
      OFS_DATA   = 2'd3
   } win_ofs_e;

   // order follows register index minus 9
   typedef enum logic [2:0] {
      TF_SEC   = 3'd0,
      TF_MIN   = 3'd1,
      TF_HOUR  = 3'd2,
      TF_WDAY  = 3'd3,
      TF_DATE  = 3'd4,
      TF_MONTH = 3'd5,
      TF_YEAR  = 3'd6
   } tod_field_e;

   typedef struct packed {
      logic       stop;
      logic       century;
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hour;
      logic [2:0] wday;
      logic [4:0] date;
      logic [3:0] month;
      logic [6:0] year;
   } tod_t;

   function automatic logic [7:0] bin2bcd(input logic [6:0] v);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = v / 7'd10;
      ones = v % 7'd10;
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [7:0] bcd2bin(input logic [7:0] v);
      return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
      case (m)
         4'd2:                   return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/nvclk_ptr.sv
module nvclk_ptr
   import nvclk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic             clr,
   input  logic [7:0]       din,
   output logic [PTR_W-1:0] ptr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else begin
         if (ld_lo) ptr[7:0]  <= din;
         if (ld_hi) ptr[15:8] <= din;
      end
   end

endmodule

// File: rtl/nvclk_store.sv
module nvclk_store #(
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wval,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rval
);

   logic [7:0] cells [DEPTH];

   // contents survive reset on purpose
   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wval;
   end

   assign rval = cells[raddr];

endmodule

// File: rtl/nvclk_tod.sv
module nvclk_tod
   import nvclk_pkg::*;
#(
   parameter int TICK_CYCLES = 32768,
   localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  tod_field_e wr_field,
   input  logic [7:0] wr_val,
   output tod_t       tod
);

   localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

   logic [PW-1:0] pre_q;
   tod_t          t_d;
   logic          tick;
   logic [7:0]    v_bin;
   logic [4:0]    mlen;

   assign tick = !tod.stop && (pre_q == PRE_LAST) && !wr_en;
   assign mlen = month_len(tod.month, tod.year);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (wr_en && wr_field == TF_SEC) begin
         pre_q <= '0;
      end else if (!tod.stop) begin
         pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      end
   end

   always_comb begin
      t_d   = tod;
      v_bin = 8'd0;
      if (wr_en) begin
         unique case (wr_field)
            TF_SEC: begin
               v_bin = bcd2bin({1'b0, wr_val[6:0]});
               if (v_bin <= 8'd59) t_d.sec = v_bin[5:0];
               t_d.stop = wr_val[7];
            end
            TF_MIN: begin
               v_bin = bcd2bin({1'b0, wr_val[6:0]});
               if (v_bin <= 8'd59) t_d.min = v_bin[5:0];
            end
            TF_HOUR: begin
               v_bin = bcd2bin({2'b0, wr_val[5:0]});
               if (v_bin <= 8'd23) t_d.hour = v_bin[4:0];
            end
            TF_WDAY: begin
               t_d.wday    = wr_val[2:0];
               t_d.century = wr_val[6];
            end
            TF_DATE: begin
               v_bin = bcd2bin({2'b0, wr_val[5:0]});
               if (v_bin != 8'd0 && v_bin <= 8'd31) t_d.date = v_bin[4:0];
            end
            TF_MONTH: begin
               v_bin = bcd2bin({3'b0, wr_val[4:0]});
               if (v_bin >= 8'd1 && v_bin <= 8'd12) t_d.month = v_bin[3:0];
            end
            TF_YEAR: begin
               v_bin = bcd2bin(wr_val);
               if (v_bin <= 8'd99) t_d.year = v_bin[6:0];
            end
            default: ;
         endcase
      end else if (tick) begin
         if (tod.sec != 6'd59) begin
            t_d.sec = tod.sec + 6'd1;
         end else begin
            t_d.sec = 6'd0;
            if (tod.min != 6'd59) begin
               t_d.min = tod.min + 6'd1;
            end else begin
               t_d.min = 6'd0;
               if (tod.hour != 5'd23) begin
                  t_d.hour = tod.hour + 5'd1;
               end else begin
                  t_d.hour = 5'd0;
                  t_d.wday = (tod.wday >= 3'd6) ? 3'd0 : tod.wday + 3'd1;
                  if (tod.date < mlen) begin
                     t_d.date = tod.date + 5'd1;
                  end else begin
                     t_d.date = 5'd1;
                     if (tod.month < 4'd12) begin
                        t_d.month = tod.month + 4'd1;
                     end else begin
                        t_d.month = 4'd1;
                        t_d.year  = (tod.year >= 7'd99) ? 7'd0 : tod.year + 7'd1;
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tod <= '{stop: 1'b0, century: 1'b0, sec: 6'd0, min: 6'd0, hour: 5'd0,
                  wday: 3'd0, date: 5'd1, month: 4'd1, year: 7'd0};
      end else begin
         tod <= t_d;
      end
   end

endmodule

// File: rtl/nvclk_port.sv
module nvclk_port
   import nvclk_pkg::*;
#(
   parameter int MEM_BYTES   = 2048,
   parameter bit HAS_ALARM   = 1'b1,
   parameter int TICK_CYCLES = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb,
   input  logic       we,
   input  logic [1:0] ofs,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);

   localparam int MEM_AW   = $clog2(MEM_BYTES);
   localparam int TOP_BASE = MEM_BYTES - 16;

   if (MEM_BYTES < 32 || MEM_BYTES > 65536 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_size
      $error("nvclk_port: MEM_BYTES must be a power of two from 32 to 65536");
   end
   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("nvclk_port: TICK_CYCLES must be at least 2");
   end

   logic [PTR_W-1:0] addr_q;
   tod_t             tod_q;
   win_ofs_e         wofs;
   logic             wr_stb, rd_stb, data_wr;
   logic             in_range, in_top, is_reg;
   logic [3:0]       ridx;
   logic             mem_we, tod_we;
   logic [7:0]       mem_wval, mem_rval, rd_byte;
   logic [7:0]       sec_bcd, min_bcd, hour_bcd, date_bcd, mon_bcd, year_bcd;

   assign wofs    = win_ofs_e'(ofs);
   assign wr_stb  = stb && we;
   assign rd_stb  = stb && !we;
   assign data_wr = wr_stb && (wofs == OFS_DATA);

   // ---------------- pointer ----------------
   nvclk_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (wr_stb && wofs == OFS_PTR_LO),
      .ld_hi (wr_stb && wofs == OFS_PTR_HI),
      .clr   (data_wr),
      .din   (wdata),
      .ptr   (addr_q)
   );

   // ---------------- decode ----------------
   assign in_range = 32'(addr_q) < MEM_BYTES;
   assign in_top   = in_range && (32'(addr_q) >= TOP_BASE);
   assign ridx     = addr_q[3:0];

   if (HAS_ALARM) begin : g_full_regs
      assign is_reg = in_top;
   end else begin : g_clock_regs
      assign is_reg = in_top && ridx[3];
   end

   assign mem_we   = data_wr && in_range &&
                     (!is_reg || (ridx >= 4'd2 && ridx <= 4'd8));
   assign mem_wval = (is_reg && ridx == 4'd8) ? ((wdata & CTRL_KEEP) | CTRL_SET) : wdata;
   assign tod_we   = data_wr && is_reg && (ridx >= 4'd9);

   // ---------------- storage ----------------
   nvclk_store #(.DEPTH(MEM_BYTES)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (addr_q[MEM_AW-1:0]),
      .wval  (mem_wval),
      .raddr (addr_q[MEM_AW-1:0]),
      .rval  (mem_rval)
   );

   // ---------------- calendar ----------------
   nvclk_tod #(.TICK_CYCLES(TICK_CYCLES)) u_tod (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tod_we),
      .wr_field (tod_field_e'(3'(ridx - 4'd9))),
      .wr_val   (wdata),
      .tod      (tod_q)
   );

   assign sec_bcd  = bin2bcd(7'(tod_q.sec));
   assign min_bcd  = bin2bcd(7'(tod_q.min));
   assign hour_bcd = bin2bcd(7'(tod_q.hour));
   assign date_bcd = bin2bcd(7'(tod_q.date));
   assign mon_bcd  = bin2bcd(7'(tod_q.month));
   assign year_bcd = bin2bcd(tod_q.year);

   // ---------------- read path ----------------
   always_comb begin
      rd_byte = 8'hFF;
      if (!in_range) begin
         rd_byte = 8'hFF;
      end else if (!is_reg) begin
         rd_byte = mem_rval;
      end else begin
         case (ridx)
            4'h1:    rd_byte = 8'h00;
            4'h9:    rd_byte = {tod_q.stop, sec_bcd[6:0]};
            4'hA:    rd_byte = min_bcd;
            4'hB:    rd_byte = hour_bcd;
            4'hC:    rd_byte = {1'b0, tod_q.century, 3'b000, tod_q.wday};
            4'hD:    rd_byte = date_bcd;
            4'hE:    rd_byte = mon_bcd;
            4'hF:    rd_byte = year_bcd;
            default: rd_byte = mem_rval;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= 8'hFF;
      end else if (rd_stb) begin
         rdata <= (wofs == OFS_DATA) ? rd_byte : 8'hFF;
      end
   end

endmodule

// File: rtl/nvclk_port_chk.sv
module nvclk_port_chk
   import nvclk_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        stb,
   input logic        we,
   input logic [1:0]  ofs,
   input logic [7:0]  wdata,
   input logic [7:0]  rdata,
   input logic [15:0] addr_q,
   input tod_t        tod
);

   assert_ptr_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stb && we && ofs == 2'd0 |=> addr_q[7:0] == $past(wdata) && $stable(addr_q[15:8]));

   assert_ptr_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stb && we && ofs == 2'd1 |=> addr_q[15:8] == $past(wdata) && $stable(addr_q[7:0]));

   assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stb && we && ofs == 2'd3 |=> addr_q == 16'h0000);

   assert_side_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb && !we && ofs != 2'd3 |=> rdata == 8'hFF);

   assert_spare_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb && we && ofs == 2'd2 |=> $stable(addr_q));

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tod.stop && !(stb && we) |=> $stable(tod));

   assert_field_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tod.sec <= 6'd59 && tod.min <= 6'd59 && tod.hour <= 5'd23 &&
      tod.month >= 4'd1 && tod.month <= 4'd12 && tod.date >= 5'd1 && tod.year <= 7'd99);

   assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb && !we) |=> $stable(rdata));

endmodule

bind nvclk_port nvclk_port_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .stb    (stb),
   .we     (we),
   .ofs    (ofs),
   .wdata  (wdata),
   .rdata  (rdata),
   .addr_q (addr_q),
   .tod    (tod_q)
);

// File: tb/tb_nvclk_port.sv
module tb_nvclk_port;

   localparam int TICK  = 20;
   localparam int NV    = 12;
   localparam int WD_CYC = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb = 1'b0;
   logic       we = 1'b0;
   logic [1:0] ofs = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   nvclk_port #(.MEM_BYTES(2048), .HAS_ALARM(1'b1), .TICK_CYCLES(TICK)) dut (
      .clk(clk), .rst_n(rst_n), .stb(stb), .we(we), .ofs(ofs),
      .wdata(wdata), .rdata(rdata)
   );

   // {req, pointer, write value, expected read-back}
   localparam logic [35:0] VEC [NV] = '{
      {4'd4,  16'h0000, 8'hA5, 8'hA5},   // R4 first byte
      {4'd4,  16'h0123, 8'h3C, 8'h3C},   // R4
      {4'd4,  16'h07EF, 8'h5A, 8'h5A},   // R4 last plain byte
      {4'd4,  16'h07F2, 8'h45, 8'h45},   // R4 alarm byte
      {4'd4,  16'h07F6, 8'h81, 8'h81},   // R4 interrupt byte
      {4'd5,  16'h07F8, 8'h00, 8'h90},   // R5
      {4'd5,  16'h07F8, 8'hFF, 8'hDF},   // R5
      {4'd5,  16'h07F8, 8'h2A, 8'h9A},   // R5
      {4'd6,  16'h07F1, 8'h77, 8'h00},   // R6 spare
      {4'd10, 16'h0800, 8'h11, 8'hFF},   // R10
      {4'd10, 16'hFFFF, 8'h22, 8'hFF},   // R10
      {4'd10, 16'h4000, 8'h33, 8'hFF}    // R10
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] o, input logic [7:0] d);
      @(negedge clk);
      stb = 1'b1; we = 1'b1; ofs = o; wdata = d;
      @(negedge clk);
      stb = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] o, output logic [7:0] d);
      @(negedge clk);
      stb = 1'b1; we = 1'b0; ofs = o;
      @(negedge clk);
      stb = 1'b0;
      d = rdata;
   endtask

   task automatic set_ptr(input logic [15:0] a);
      wr(2'd0, a[7:0]);
      wr(2'd1, a[15:8]);
   endtask

   task automatic poke(input logic [15:0] a, input logic [7:0] d);
      set_ptr(a);
      wr(2'd3, d);
   endtask

   task automatic peek(input logic [15:0] a, output logic [7:0] d);
      set_ptr(a);
      rd(2'd3, d);
   endtask

   initial begin : watchdog
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      logic [7:0] f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rdata after reset", rdata, 8'hFF);

      // table walk
      for (int i = 0; i < NV; i++) begin
         poke(VEC[i][31:16], VEC[i][15:8]);
         peek(VEC[i][31:16], v);
         chk($sformatf("R%0d vector %0d", VEC[i][35:32], i), v, VEC[i][7:0]);
      end

      // R1: high byte first, then low byte
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h23);
      rd(2'd3, v);
      chk("R1 pointer bytes", v, 8'h3C);

      // R2: data write clears the pointer
      poke(16'h0123, 8'h66);
      rd(2'd3, v);
      chk("R2 pointer cleared after write", v, 8'hA5);
      peek(16'h0123, v);
      chk("R2 byte stored", v, 8'h66);

      // R3: side offsets
      rd(2'd0, v); chk("R3 read offset 0", v, 8'hFF);
      rd(2'd1, v); chk("R3 read offset 1", v, 8'hFF);
      rd(2'd2, v); chk("R3 read offset 2", v, 8'hFF);
      set_ptr(16'h0123);
      wr(2'd2, 8'h55);
      rd(2'd3, v);
      chk("R3 spare write ignored", v, 8'h66);

      // R13: rdata holds without a read strobe
      wr(2'd0, 8'h00);
      repeat (3) @(negedge clk);
      chk("R13 rdata hold", rdata, 8'h66);

      // R10: writes beyond the store do not alias
      poke(16'h0001, 8'h12);
      poke(16'h0801, 8'h99);
      peek(16'h0001, v);
      chk("R10 no alias write", v, 8'h12);

      // R6: flags read-only
      peek(16'h07F0, f0);
      poke(16'h07F0, ~f0);
      peek(16'h07F0, v);
      chk("R6 flags read-only", v, f0);

      // R7: stop and freeze
      poke(16'h07F9, 8'hB0);
      peek(16'h07F9, v);
      chk("R7 stop set, seconds 30", v, 8'hB0);
      repeat (100) @(negedge clk);
      peek(16'h07F9, v);
      chk("R7 frozen", v, 8'hB0);

      // R8: load fields, then out-of-range writes
      poke(16'h07FA, 8'h59);
      poke(16'h07FB, 8'h23);
      poke(16'h07FD, 8'h28);
      poke(16'h07FE, 8'h02);
      poke(16'h07FF, 8'h01);
      poke(16'h07FC, 8'h46);
      poke(16'h07FA, 8'h60); peek(16'h07FA, v); chk("R8 minutes 60 ignored", v, 8'h59);
      poke(16'h07FB, 8'h24); peek(16'h07FB, v); chk("R8 hours 24 ignored", v, 8'h23);
      poke(16'h07FE, 8'h13); peek(16'h07FE, v); chk("R8 month 13 ignored", v, 8'h02);
      poke(16'h07FE, 8'h00); peek(16'h07FE, v); chk("R8 month 0 ignored", v, 8'h02);
      poke(16'h07FD, 8'h00); peek(16'h07FD, v); chk("R8 date 0 ignored", v, 8'h28);
      poke(16'h07FF, 8'h9A); peek(16'h07FF, v); chk("R8 year 9A ignored", v, 8'h01);
      peek(16'h07FC, v);
      chk("R12 weekday and century", v, 8'h46);

      // R9: 23:59:58 Feb 28 year 01 runs two ticks into Mar 1
      poke(16'h07F9, 8'h58);
      repeat (45) @(negedge clk);
      poke(16'h07F9, 8'hFF);   // stop only, seconds out of range
      peek(16'h07F9, v); chk("R7 stop-only write keeps seconds", v, 8'h80);
      peek(16'h07FA, v); chk("R9 minutes wrap", v, 8'h00);
      peek(16'h07FB, v); chk("R9 hours wrap", v, 8'h00);
      peek(16'h07FD, v); chk("R9 date to 1", v, 8'h01);
      peek(16'h07FE, v); chk("R9 month to 3", v, 8'h03);
      peek(16'h07FF, v); chk("R9 year kept", v, 8'h01);
      peek(16'h07FC, v); chk("R12 weekday wraps at midnight", v, 8'h40);

      // R9: leap year Feb 28 goes to Feb 29
      poke(16'h07FF, 8'h04);
      poke(16'h07FE, 8'h02);
      poke(16'h07FD, 8'h28);
      poke(16'h07FB, 8'h23);
      poke(16'h07FA, 8'h59);
      poke(16'h07F9, 8'h59);
      repeat (25) @(negedge clk);
      poke(16'h07F9, 8'hFF);
      peek(16'h07FD, v); chk("R9 leap date 29", v, 8'h29);
      peek(16'h07FE, v); chk("R9 leap month kept", v, 8'h02);
      peek(16'h07FB, v); chk("R7 resumed to midnight", v, 8'h00);

      // R11: reset keeps the store and clears the pointer
      set_ptr(16'h0123);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rdata reset", rdata, 8'hFF);
      rd(2'd3, v);
      chk("R11 pointer zero, store kept", v, 8'hA5);
      peek(16'h07F9, v);
      chk("R11 calendar running after reset", v[7], 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule